// File: doc/BRIEF.md
# 32/40-bit Bus Beat Packer

This block joins a 32-bit memory bus to a datapath whose words are 40 bits wide. On the fetch side it collects bus beats and hands whole words to the datapath. On the store side it takes whole words from the datapath and breaks them into bus beats. Every edge uses a valid/ready handshake. A single mode input picks between two formats:

- **Wide mode** packs each 40-bit word into two beats. The first beat holds the low 32 bits of the word. The low byte of the second beat holds bits 39:32.
- **Narrow mode** treats each beat as one 32-bit word.

Fetched words carry a one-bit kind tag, 0 for input data and 1 for coefficients. The tag is taken from the first beat of the word. Both kinds use the same packing, and so do stored results. The mode is sampled only at a word boundary. A synchronous clear drops any half-moved word and returns both sides to the first beat.

Top module: `w40_beat_packer`

## Requirements
- R1: In wide mode (`wide_mode_i`=1) two accepted fetch beats A then B yield one word equal to {B[7:0], A[31:0]}; bits 31:8 of B have no effect on the word.
- R2: In narrow mode (`wide_mode_i`=0) every accepted fetch beat D yields one word {8'h00, D[31:0]}.
- R3: In wide mode a stored word W leaves as two beats: first W[31:0] with `wr_beat_last_o`=0, then {24'h000000, W[39:32]} with `wr_beat_last_o`=1.
- R4: In narrow mode a stored word W leaves as one beat W[31:0] with `wr_beat_last_o`=1; bits 39:32 of W have no effect.
- R5: A fetched word is presented on `rd_word_valid_o` only in the cycle after the beat that completes it is accepted; a lone first beat in wide mode produces no word.
- R6: While a receiver holds ready low, the offered word or beat and its valid stay unchanged; under any pattern of backpressure no word or beat is lost, duplicated or reordered.
- R7: Changing `wide_mode_i` after the first beat of a fetched word is accepted, or after a stored word is accepted, has no effect on that word; the new mode applies from the next word.
- R8: While `clr_i` is high, `rd_beat_ready_o` and `wr_word_ready_o` are low. After the clear, a half-gathered fetch word and any stored word not yet fully sent are discarded, and the next fetch beat is treated as a first beat.
- R9: `rd_word_tag_o` equals the tag (0 data, 1 coefficient) that came with the first beat of that word; the tag on a second beat is ignored.
- R10: After reset no word or beat is offered (`rd_word_valid_o`=0, `wr_beat_valid_o`=0), and both `rd_beat_ready_o` and `wr_word_ready_o` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of both beat positions |
| wide_mode_i | input | 1 | 1 = two beats per 40-bit word, 0 = one 32-bit beat per word |
| rd_beat_valid_i | input | 1 | Fetch beat offered by the bus |
| rd_beat_ready_o | output | 1 | Fetch beat accepted |
| rd_beat_data_i | input | 32 | Fetch beat payload |
| rd_beat_tag_i | input | 1 | Kind of fetched word: 0 data, 1 coefficient |
| rd_word_valid_o | output | 1 | Assembled word offered to the datapath |
| rd_word_ready_i | input | 1 | Datapath takes the word |
| rd_word_data_o | output | 40 | Assembled word |
| rd_word_tag_o | output | 1 | Kind of the assembled word |
| wr_word_valid_i | input | 1 | Result word offered by the datapath |
| wr_word_ready_o | output | 1 | Result word accepted |
| wr_word_data_i | input | 40 | Result word |
| wr_beat_valid_o | output | 1 | Store beat offered to the bus |
| wr_beat_ready_i | input | 1 | Bus takes the store beat |
| wr_beat_data_o | output | 32 | Store beat payload |
| wr_beat_last_o | output | 1 | Marks the final beat of a stored word |

## Verification
The checker looks at every cycle and tests four things:

- It confirms that offered words and beats stay frozen under backpressure.
- It confirms that a store beat following a non-final beat is final and carries only the high byte.
- It confirms that a fetched word appears only right after an accepted beat.
- It confirms that the clear blocks intake and empties the store side.

The rest can only be shown by the bench's scenarios:

- the actual packing arithmetic in both modes;
- that the high bits of a second beat and the top byte of a narrow word are ignored;
- that a mode change in mid-word has no effect;
- that the first-beat tag is carried;
- that nothing is lost across long sweeps of mixed modes and random stalls.

// File: rtl/w40_pkg.sv
package w40_pkg;

   // Position of the next beat within a word
   typedef enum logic {
      BEAT_FIRST  = 1'b0,
      BEAT_SECOND = 1'b1
   } beat_pos_e;

   // Number of bits that spill into the second beat
   function automatic int hi_width(input int word_w, input int bus_w);
      return word_w - bus_w;
   endfunction

endpackage

// File: rtl/w40_beat_track.sv
module w40_beat_track
   import w40_pkg::*;
#(
   parameter bit NARROW_EN = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic fire_i,
   input  logic mode_i,
   output logic first_o,
   output logic last_o,
   output logic wide_o
);

   beat_pos_e pos_q;
   logic      wide_q;
   logic      mode_live;

   // Variant: with narrow support the mode input is live, otherwise always wide
   generate
      if (NARROW_EN) begin : g_mode_live
         assign mode_live = mode_i;
      end else begin : g_mode_fixed
         logic unused_mode;
         assign unused_mode = mode_i;
         assign mode_live   = 1'b1;
      end
   endgenerate

   // Mode is taken live at a word boundary, and held once a word has started
   assign wide_o  = (pos_q == BEAT_SECOND) ? wide_q : mode_live;
   assign first_o = (pos_q == BEAT_FIRST);
   assign last_o  = !wide_o || (pos_q == BEAT_SECOND);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pos_q  <= BEAT_FIRST;
         wide_q <= 1'b0;
      end else if (clr_i) begin
         pos_q  <= BEAT_FIRST;
      end else if (fire_i) begin
         pos_q <= last_o ? BEAT_FIRST : BEAT_SECOND;
         if (pos_q == BEAT_FIRST) begin
            wide_q <= mode_live;
         end
      end
   end

endmodule

// File: rtl/w40_gather.sv
module w40_gather
   import w40_pkg::*;
#(
   parameter int BUS_W     = 32,
   parameter int WORD_W    = 40,
   parameter int TAG_W     = 1,
   parameter bit NARROW_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_i,
   input  logic              wide_mode_i,
   input  logic              beat_valid_i,
   output logic              beat_ready_o,
   input  logic [BUS_W-1:0]  beat_data_i,
   input  logic [TAG_W-1:0]  beat_tag_i,
   output logic              word_valid_o,
   input  logic              word_ready_i,
   output logic [WORD_W-1:0] word_data_o,
   output logic [TAG_W-1:0]  word_tag_o
);

   localparam int HI_W = hi_width(WORD_W, BUS_W);

   logic              fire;
   logic              first;
   logic              last;
   logic              wide;
   logic              slot_free;
   logic [BUS_W-1:0]  lo_q;
   logic [TAG_W-1:0]  tag_q;
   logic              out_valid_q;
   logic [WORD_W-1:0] out_data_q;
   logic [TAG_W-1:0]  out_tag_q;
   logic [WORD_W-1:0] assembled;
   logic [TAG_W-1:0]  word_tag;

   w40_beat_track #(
      .NARROW_EN (NARROW_EN)
   ) trk_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr_i),
      .fire_i  (fire),
      .mode_i  (wide_mode_i),
      .first_o (first),
      .last_o  (last),
      .wide_o  (wide)
   );

   // The output register is free if it is empty or being drained this cycle
   assign slot_free = !out_valid_q || word_ready_i;

   // A first beat of a wide word only fills the low holding register
   assign beat_ready_o = !clr_i && (last ? slot_free : 1'b1);
   assign fire         = beat_valid_i && beat_ready_o;

   always_comb begin
      if (wide) begin
         assembled = {beat_data_i[HI_W-1:0], lo_q};
      end else begin
         assembled = {{HI_W{1'b0}}, beat_data_i};
      end
      word_tag = first ? beat_tag_i : tag_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lo_q  <= '0;
         tag_q <= '0;
      end else if (fire && first && !last) begin
         lo_q  <= beat_data_i;
         tag_q <= beat_tag_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         out_valid_q <= 1'b0;
         out_data_q  <= '0;
         out_tag_q   <= '0;
      end else begin
         if (word_ready_i) begin
            out_valid_q <= 1'b0;
         end
         if (fire && last) begin
            out_valid_q <= 1'b1;
            out_data_q  <= assembled;
            out_tag_q   <= word_tag;
         end
      end
   end

   assign word_valid_o = out_valid_q;
   assign word_data_o  = out_data_q;
   assign word_tag_o   = out_tag_q;

endmodule

// File: rtl/w40_split.sv
module w40_split
   import w40_pkg::*;
#(
   parameter int BUS_W     = 32,
   parameter int WORD_W    = 40,
   parameter bit NARROW_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_i,
   input  logic              wide_mode_i,
   input  logic              word_valid_i,
   output logic              word_ready_o,
   input  logic [WORD_W-1:0] word_data_i,
   output logic              beat_valid_o,
   input  logic              beat_ready_i,
   output logic [BUS_W-1:0]  beat_data_o,
   output logic              beat_last_o
);

   localparam int HI_W = hi_width(WORD_W, BUS_W);

   logic              hold_valid_q;
   logic [WORD_W-1:0] hold_q;
   logic              hold_wide_q;
   logic              beat_fire;
   logic              word_fire;
   logic              first;
   logic              last;
   logic              wide;
   logic [BUS_W-1:0]  hi_beat;

   w40_beat_track #(
      .NARROW_EN (NARROW_EN)
   ) trk_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr_i),
      .fire_i  (beat_fire),
      .mode_i  (hold_wide_q),
      .first_o (first),
      .last_o  (last),
      .wide_o  (wide)
   );

   // Zero padding only exists when the spill part is narrower than a beat
   generate
      if (HI_W < BUS_W) begin : g_pad
         assign hi_beat = {{(BUS_W-HI_W){1'b0}}, hold_q[WORD_W-1:BUS_W]};
      end else begin : g_nopad
         assign hi_beat = hold_q[WORD_W-1:BUS_W];
      end
   endgenerate

   assign beat_valid_o = hold_valid_q;
   assign beat_last_o  = last;
   assign beat_data_o  = (first || !wide) ? hold_q[BUS_W-1:0] : hi_beat;
   assign beat_fire    = hold_valid_q && beat_ready_i;

   // A new word may enter as the final beat of the held one leaves
   assign word_ready_o = !clr_i && (!hold_valid_q || (beat_ready_i && last));
   assign word_fire    = word_valid_i && word_ready_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hold_valid_q <= 1'b0;
         hold_q       <= '0;
         hold_wide_q  <= 1'b0;
      end else if (clr_i) begin
         hold_valid_q <= 1'b0;
      end else begin
         if (beat_fire && last) begin
            hold_valid_q <= 1'b0;
         end
         if (word_fire) begin
            hold_valid_q <= 1'b1;
            hold_q       <= word_data_i;
            hold_wide_q  <= wide_mode_i;
         end
      end
   end

endmodule

// File: rtl/w40_beat_packer.sv
module w40_beat_packer
   import w40_pkg::*;
#(
   parameter int BUS_W     = 32,
   parameter int WORD_W    = 40,
   parameter int TAG_W     = 1,
   parameter bit NARROW_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_i,
   input  logic              wide_mode_i,
   input  logic              rd_beat_valid_i,
   output logic              rd_beat_ready_o,
   input  logic [BUS_W-1:0]  rd_beat_data_i,
   input  logic [TAG_W-1:0]  rd_beat_tag_i,
   output logic              rd_word_valid_o,
   input  logic              rd_word_ready_i,
   output logic [WORD_W-1:0] rd_word_data_o,
   output logic [TAG_W-1:0]  rd_word_tag_o,
   input  logic              wr_word_valid_i,
   output logic              wr_word_ready_o,
   input  logic [WORD_W-1:0] wr_word_data_i,
   output logic              wr_beat_valid_o,
   input  logic              wr_beat_ready_i,
   output logic [BUS_W-1:0]  wr_beat_data_o,
   output logic              wr_beat_last_o
);

   // Elaboration-time parameter checks
   generate
      if (WORD_W <= BUS_W || WORD_W > 2*BUS_W) begin : g_bad_width
         $error("WORD_W must exceed BUS_W and fit in two beats");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("TAG_W must be at least 1");
      end
   endgenerate

   w40_gather #(
      .BUS_W     (BUS_W),
      .WORD_W    (WORD_W),
      .TAG_W     (TAG_W),
      .NARROW_EN (NARROW_EN)
   ) gather_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .clr_i        (clr_i),
      .wide_mode_i  (wide_mode_i),
      .beat_valid_i (rd_beat_valid_i),
      .beat_ready_o (rd_beat_ready_o),
      .beat_data_i  (rd_beat_data_i),
      .beat_tag_i   (rd_beat_tag_i),
      .word_valid_o (rd_word_valid_o),
      .word_ready_i (rd_word_ready_i),
      .word_data_o  (rd_word_data_o),
      .word_tag_o   (rd_word_tag_o)
   );

   w40_split #(
      .BUS_W     (BUS_W),
      .WORD_W    (WORD_W),
      .NARROW_EN (NARROW_EN)
   ) split_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .clr_i        (clr_i),
      .wide_mode_i  (wide_mode_i),
      .word_valid_i (wr_word_valid_i),
      .word_ready_o (wr_word_ready_o),
      .word_data_i  (wr_word_data_i),
      .beat_valid_o (wr_beat_valid_o),
      .beat_ready_i (wr_beat_ready_i),
      .beat_data_o  (wr_beat_data_o),
      .beat_last_o  (wr_beat_last_o)
   );

endmodule

// File: rtl/w40_beat_packer_chk.sv
module w40_beat_packer_chk #(
   parameter int BUS_W  = 32,
   parameter int WORD_W = 40,
   parameter int TAG_W  = 1
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              clr_i,
   input logic              rd_beat_valid_i,
   input logic              rd_beat_ready_o,
   input logic              rd_word_valid_o,
   input logic              rd_word_ready_i,
   input logic [WORD_W-1:0] rd_word_data_o,
   input logic [TAG_W-1:0]  rd_word_tag_o,
   input logic              wr_word_ready_o,
   input logic              wr_beat_valid_o,
   input logic              wr_beat_ready_i,
   input logic [BUS_W-1:0]  wr_beat_data_o,
   input logic              wr_beat_last_o
);

   localparam int HI_W = WORD_W - BUS_W;

   // Observed at the store bus: is the next beat the start of a word
   logic wr_at_start_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wr_at_start_q <= 1'b1;
      end else if (clr_i) begin
         wr_at_start_q <= 1'b1;
      end else if (wr_beat_valid_o && wr_beat_ready_i) begin
         wr_at_start_q <= wr_beat_last_o;
      end
   end

   AST_WR_SECOND_IS_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_beat_valid_o && !wr_at_start_q) |-> wr_beat_last_o); // R3

   AST_WR_SECOND_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_beat_valid_o && !wr_at_start_q) |-> ((wr_beat_data_o >> HI_W) == '0)); // R3

   AST_RD_WORD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_word_valid_o && !rd_word_ready_i) |=>
         (rd_word_valid_o && $stable(rd_word_data_o) && $stable(rd_word_tag_o))); // R6

   AST_WR_BEAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_beat_valid_o && !wr_beat_ready_i && !clr_i) |=>
         (wr_beat_valid_o && $stable(wr_beat_data_o) && $stable(wr_beat_last_o))); // R6

   AST_RD_WORD_AFTER_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rd_word_valid_o) |-> $past(rd_beat_valid_i && rd_beat_ready_o)); // R5

   AST_CLR_BLOCKS_INTAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |-> (!rd_beat_ready_o && !wr_word_ready_o)); // R8

   AST_CLR_EMPTIES_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> !wr_beat_valid_o); // R8

endmodule

bind w40_beat_packer w40_beat_packer_chk #(
   .BUS_W  (BUS_W),
   .WORD_W (WORD_W),
   .TAG_W  (TAG_W)
) chk_i (
   .clk_i           (clk_i),
   .rst_ni          (rst_ni),
   .clr_i           (clr_i),
   .rd_beat_valid_i (rd_beat_valid_i),
   .rd_beat_ready_o (rd_beat_ready_o),
   .rd_word_valid_o (rd_word_valid_o),
   .rd_word_ready_i (rd_word_ready_i),
   .rd_word_data_o  (rd_word_data_o),
   .rd_word_tag_o   (rd_word_tag_o),
   .wr_word_ready_o (wr_word_ready_o),
   .wr_beat_valid_o (wr_beat_valid_o),
   .wr_beat_ready_i (wr_beat_ready_i),
   .wr_beat_data_o  (wr_beat_data_o),
   .wr_beat_last_o  (wr_beat_last_o)
);

// File: tb/w40_beat_packer_tb_top.sv
`timescale 1ns/1ps
module w40_beat_packer_tb_top;

   logic        clk_i = 1'b0;
   logic        rst_ni;
   logic        clr_i;
   logic        wide_mode_i;
   logic        rd_beat_valid_i;
   logic        rd_beat_ready_o;
   logic [31:0] rd_beat_data_i;
   logic [0:0]  rd_beat_tag_i;
   logic        rd_word_valid_o;
   logic        rd_word_ready_i;
   logic [39:0] rd_word_data_o;
   logic [0:0]  rd_word_tag_o;
   logic        wr_word_valid_i;
   logic        wr_word_ready_o;
   logic [39:0] wr_word_data_i;
   logic        wr_beat_valid_o;
   logic        wr_beat_ready_i;
   logic [31:0] wr_beat_data_o;
   logic        wr_beat_last_o;

   always #2 clk_i = ~clk_i;

   w40_beat_packer dut_i (
      .clk_i           (clk_i),
      .rst_ni          (rst_ni),
      .clr_i           (clr_i),
      .wide_mode_i     (wide_mode_i),
      .rd_beat_valid_i (rd_beat_valid_i),
      .rd_beat_ready_o (rd_beat_ready_o),
      .rd_beat_data_i  (rd_beat_data_i),
      .rd_beat_tag_i   (rd_beat_tag_i),
      .rd_word_valid_o (rd_word_valid_o),
      .rd_word_ready_i (rd_word_ready_i),
      .rd_word_data_o  (rd_word_data_o),
      .rd_word_tag_o   (rd_word_tag_o),
      .wr_word_valid_i (wr_word_valid_i),
      .wr_word_ready_o (wr_word_ready_o),
      .wr_word_data_i  (wr_word_data_i),
      .wr_beat_valid_o (wr_beat_valid_o),
      .wr_beat_ready_i (wr_beat_ready_i),
      .wr_beat_data_o  (wr_beat_data_o),
      .wr_beat_last_o  (wr_beat_last_o)
   );

   int          n_chk = 0;
   int          n_bad = 0;
   bit          finished = 1'b0;
   int          rd_bp = 0;   // 0 always ready, 1 random, 2 stalled
   int          wr_bp = 0;
   logic [15:0] lfsr_r = 16'hACE1;
   logic [15:0] lfsr_w = 16'h1D0F;
   logic [40:0] rd_exp_q[$];
   string       rd_req_q[$];
   logic [32:0] wr_exp_q[$];
   string       wr_req_q[$];

   task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // Datapath side of the fetch path
   initial begin
      rd_word_ready_i = 1'b0;
      forever begin
         @(posedge clk_i); #1;
         lfsr_r = {lfsr_r[14:0], lfsr_r[15] ^ lfsr_r[13] ^ lfsr_r[12] ^ lfsr_r[10]};
         rd_word_ready_i = (rd_bp == 0) ? 1'b1 : ((rd_bp == 1) ? lfsr_r[0] : 1'b0);
         @(negedge clk_i);
         if (rst_ni && rd_word_valid_o && rd_word_ready_i) begin
            if (rd_exp_q.size() == 0) begin
               chk(1'b0, "R6 extra word", {23'd0, rd_word_tag_o, rd_word_data_o}, 64'd0);
            end else begin
               automatic logic [40:0] e = rd_exp_q.pop_front();
               automatic string       r = rd_req_q.pop_front();
               chk({rd_word_tag_o, rd_word_data_o} == e, r, {23'd0, rd_word_tag_o, rd_word_data_o}, {23'd0, e});
            end
         end
      end
   end

   // Bus side of the store path
   initial begin
      wr_beat_ready_i = 1'b0;
      forever begin
         @(posedge clk_i); #1;
         lfsr_w = {lfsr_w[14:0], lfsr_w[15] ^ lfsr_w[13] ^ lfsr_w[12] ^ lfsr_w[10]};
         wr_beat_ready_i = (wr_bp == 0) ? 1'b1 : ((wr_bp == 1) ? lfsr_w[0] : 1'b0);
         @(negedge clk_i);
         if (rst_ni && wr_beat_valid_o && wr_beat_ready_i) begin
            if (wr_exp_q.size() == 0) begin
               chk(1'b0, "R6 extra beat", {31'd0, wr_beat_last_o, wr_beat_data_o}, 64'd0);
            end else begin
               automatic logic [32:0] e = wr_exp_q.pop_front();
               automatic string       r = wr_req_q.pop_front();
               chk({wr_beat_last_o, wr_beat_data_o} == e, r, {31'd0, wr_beat_last_o, wr_beat_data_o}, {31'd0, e});
            end
         end
      end
   end

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk_i);
      chk(1'b0, "watchdog expired", 64'd0, 64'd1);
      summary();
   end

   // Callers enter just after a rising edge
   task automatic rd_push(input logic [31:0] d, input logic t);
      rd_beat_valid_i = 1'b1;
      rd_beat_data_i  = d;
      rd_beat_tag_i   = t;
      do @(negedge clk_i); while (!rd_beat_ready_o);
      @(posedge clk_i); #1;
      rd_beat_valid_i = 1'b0;
   endtask

   task automatic rd_word(input logic [39:0] w, input bit wide, input logic t, input bit flip,
                          input logic [23:0] junk, input bit expect_it, input string req);
      wide_mode_i = wide;
      if (expect_it) begin
         rd_exp_q.push_back(wide ? {t, w} : {t, 8'h00, w[31:0]});
         rd_req_q.push_back(req);
      end
      rd_push(w[31:0], t);
      if (wide) begin
         if (flip) wide_mode_i = ~wide;
         rd_push({junk, w[39:32]}, ~t);
      end
   endtask

   task automatic wr_word(input logic [39:0] w, input bit wide, input bit flip,
                          input bit expect_it, input string req);
      wide_mode_i     = wide;
      wr_word_valid_i = 1'b1;
      wr_word_data_i  = w;
      if (expect_it) begin
         if (wide) begin
            wr_exp_q.push_back({1'b0, w[31:0]});
            wr_req_q.push_back(req);
            wr_exp_q.push_back({1'b1, 24'h000000, w[39:32]});
            wr_req_q.push_back(req);
         end else begin
            wr_exp_q.push_back({1'b1, w[31:0]});
            wr_req_q.push_back(req);
         end
      end
      do @(negedge clk_i); while (!wr_word_ready_o);
      @(posedge clk_i); #1;
      wr_word_valid_i = 1'b0;
      if (flip) wide_mode_i = ~wide;
   endtask

   task automatic drain(input string req);
      for (int k = 0; k < 400; k++) begin
         if (rd_exp_q.size() == 0 && wr_exp_q.size() == 0) break;
         @(posedge clk_i); #1;
      end
      chk(rd_exp_q.size() == 0 && wr_exp_q.size() == 0, req,
          64'(rd_exp_q.size() + wr_exp_q.size()), 64'd0);
   endtask

   function automatic logic [39:0] mk_word(input int i);
      logic [31:0] lo;
      lo = (32'(i) * 32'h9E3779B1) ^ 32'h5A5A_C3C3;
      return {i[7:0], lo};
   endfunction

   initial begin
      rst_ni          = 1'b0;
      clr_i           = 1'b0;
      wide_mode_i     = 1'b1;
      rd_beat_valid_i = 1'b0;
      rd_beat_data_i  = '0;
      rd_beat_tag_i   = '0;
      wr_word_valid_i = 1'b0;
      wr_word_data_i  = '0;
      repeat (3) @(posedge clk_i);
      #1 rst_ni = 1'b1;

      // R10: idle state after reset
      @(negedge clk_i);
      chk(rd_word_valid_o == 1'b0, "R10 rd_word_valid", 64'(rd_word_valid_o), 64'd0);
      chk(wr_beat_valid_o == 1'b0, "R10 wr_beat_valid", 64'(wr_beat_valid_o), 64'd0);
      chk(rd_beat_ready_o == 1'b1, "R10 rd_beat_ready", 64'(rd_beat_ready_o), 64'd1);
      chk(wr_word_ready_o == 1'b1, "R10 wr_word_ready", 64'(wr_word_ready_o), 64'd1);
      @(posedge clk_i); #1;

      // R5: a lone first beat yields no word
      rd_bp = 0;
      wide_mode_i = 1'b1;
      rd_exp_q.push_back({1'b1, 40'hA5_1234_5678});
      rd_req_q.push_back("R5 R1");
      rd_push(32'h1234_5678, 1'b1);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk_i);
         chk(rd_word_valid_o == 1'b0, "R5 no word after one beat", 64'(rd_word_valid_o), 64'd0);
         @(posedge clk_i); #1;
      end
      rd_push(32'hFFFF_FFA5, 1'b0);
      @(negedge clk_i);
      chk(rd_word_valid_o == 1'b1, "R5 word after second beat", 64'(rd_word_valid_o), 64'd1);
      @(posedge clk_i); #1;
      drain("R5 drain");

      // Fetch sweep: R1 R2 R7 R9 under varied backpressure (R6)
      for (int i = 0; i < 320; i++) begin
         automatic bit   wide = (i < 256) ? (i % 4 != 3) : i[0];
         automatic bit   flip = (i % 5 == 0);
         automatic logic t    = i[1];
         automatic string req = !wide ? "R2 R9" : (flip ? "R7 R1" : "R1 R9");
         rd_bp = (i < 100) ? 0 : 1;
         rd_word(mk_word(i), wide, t, flip, 24'(32'(i) * 32'h00C0FFEE), 1'b1, req);
         if (i % 7 == 0) begin
            @(posedge clk_i); #1;
         end
      end
      drain("R6 fetch no loss");

      // R8: clear drops a half-gathered fetch word
      rd_bp = 0;
      wide_mode_i = 1'b1;
      rd_push(32'hDEAD_BEEF, 1'b0);
      clr_i = 1'b1;
      @(negedge clk_i);
      chk(rd_beat_ready_o == 1'b0 && wr_word_ready_o == 1'b0, "R8 intake blocked",
          {62'd0, rd_beat_ready_o, wr_word_ready_o}, 64'd0);
      @(posedge clk_i); #1;
      clr_i = 1'b0;
      rd_word(40'h3C_0BAD_F00D, 1'b1, 1'b1, 1'b0, 24'hFFFFFF, 1'b1, "R8 fetch after clear");
      drain("R8 fetch drain");

      // Store sweep: R3 R4 R7 under varied backpressure (R6)
      for (int i = 0; i < 320; i++) begin
         automatic bit   wide = (i < 256) ? (i % 4 != 3) : i[0];
         automatic bit   flip = (i % 5 == 0);
         automatic string req = flip ? "R7 store" : (wide ? "R3" : "R4");
         wr_bp = (i < 100) ? 0 : 1;
         wr_word(mk_word(i + 1000), wide, flip, 1'b1, req);
         if (i % 6 == 0) begin
            @(posedge clk_i); #1;
         end
      end
      drain("R6 store no loss");

      // R8: clear drops a stored word still waiting on the bus
      wr_bp = 2;
      wr_word(40'h77_1111_2222, 1'b1, 1'b0, 1'b0, "");
      @(negedge clk_i);
      chk(wr_beat_valid_o == 1'b1, "R6 beat held under stall", 64'(wr_beat_valid_o), 64'd1);
      @(posedge clk_i); #1;
      clr_i = 1'b1;
      @(posedge clk_i); #1;
      clr_i = 1'b0;
      @(negedge clk_i);
      chk(wr_beat_valid_o == 1'b0, "R8 store emptied", 64'(wr_beat_valid_o), 64'd0);
      @(posedge clk_i); #1;
      wr_bp = 0;
      wr_word(40'h5E_4444_3333, 1'b1, 1'b0, 1'b1, "R8 store after clear");
      drain("R8 store drain");

      summary();
   end

endmodule